// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block is the memory-mapped face of a block-cipher engine. A host on a 32-bit word-addressed bus with a 5-bit address writes a key and an input block. It then writes one control word that selects encryption or decryption. The front-end hands the stored key and block to the engine over a start/done handshake and captures the engine's output. It raises an interrupt when the result can be read back. The cipher rounds and the key schedule belong to the engine and are outside this block.

The front-end tracks whether the key currently held by the engine has already been expanded. The first operation after a key becomes valid sends one key-load request and waits for the engine's done flag before it starts the block operation. Later operations, in either direction, reuse the expanded key. That lasts until software rewrites a key word or clears the key-valid bit. Writes that would disturb the key or the block during an operation are stalled with waitrequest.

Top module: `blkc_regfront`

## Requirements
- R1: Key words are written at addresses 0 to KEY_BITS/32-1. Address 0 holds the most significant word of `eng_key`.
- R2: The input block is written at addresses 8 to 11. Address 8 holds bits 127:96 of `eng_block`.
- R3: With `bus_cs` and `bus_rd` high, `bus_rdata` returns result word k from address 16+k in the same cycle, with address 16 returning bits 127:96. Key and block addresses read as zero, and `bus_rdata` is zero when no read is made.
- R4: Address 31 is control. Bit 7 is key valid, bit 6 is interrupt enable, bit 1 starts a decryption and bit 0 starts an encryption, so 0xC1 encrypts and 0xC2 decrypts. Control reads back as {key valid, interrupt enable, 4'b0, start bits}. The start bits clear once taken, so after an operation control reads 0xC0.
- R5: The first start after the key becomes valid or after any key word is written issues exactly one `eng_keyload` pulse. The block start follows only after that load's `eng_done`. Later starts issue no key-load pulse.
- R6: Repeating a command without reloading key or block returns the same result, and an encryption after a decryption is unaffected by it.
- R7: Writing 0 to control clears key valid. A start written while key valid is clear sends no request to the engine and raises no interrupt. After new key words and 0xC1, a key load is issued again.
- R8: `irq` rises on the clock edge after the block operation's `eng_done` when interrupt enable is set. It stays low when interrupt enable is clear, and the result is still captured.
- R9: `irq` is cleared by a read of any result address or by an accepted control write.
- R10: While an operation is pending or active, a write to a key, block or control address sees `bus_wait` high in that cycle. The write takes effect only when `bus_wait` drops, so the running operation uses the old values.
- R11: After reset `irq`, `eng_keyload` and `eng_start` are low and control reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Slave select |
| bus_addr | input | 5 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_wait | output | 1 | Stall for the current write |
| irq | output | 1 | Completion interrupt |
| eng_key | output | KEY_BITS | Stored key to engine |
| eng_block | output | 128 | Stored input block to engine |
| eng_key_valid | output | 1 | Key-valid bit to engine |
| eng_keyload | output | 1 | One-cycle key expansion request |
| eng_start | output | 1 | One-cycle block operation request |
| eng_decrypt | output | 1 | Direction of the current operation |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 128 | Engine output block |

## Verification
`bus_rdata` and `bus_wait` are combinational, so the bench samples them one time step after driving a request, before the edge that accepts it. The bench's engine stub flags the done pulse of a block operation, and `irq` is checked exactly one clock later. The result words are then read back at once. The control start bits are taken on the edge after the control write, and the key-load request follows one edge later. The bench therefore compares key-load and start counts only after the interrupt point, and for rejected commands only after a fixed quiet window of cycles.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_BASE = 8;
  localparam int unsigned RES_BASE  = 16;
  localparam int unsigned CTRL_ADDR = 31;
  localparam int unsigned CB_ENC    = 0;
  localparam int unsigned CB_DEC    = 1;
  localparam int unsigned CB_IE     = 6;
  localparam int unsigned CB_KV     = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KREQ,
    ST_KWAIT,
    ST_BREQ,
    ST_BWAIT
  } seq_state_e;
endpackage

// File: rtl/blkc_regbank.sv
module blkc_regbank
  import blkc_pkg::*;
#(
  parameter int unsigned KEY_BITS = 128,
  parameter int unsigned BLK_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ok,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                res_load,
  input  logic [BLK_BITS-1:0] res_in,
  output logic [KEY_BITS-1:0] key_out,
  output logic [BLK_BITS-1:0] blk_out,
  output logic [WORD_W-1:0]   res_word,
  output logic                key_touch
);
  localparam int unsigned KEY_WORDS = KEY_BITS / WORD_W;
  localparam int unsigned BLK_WORDS = BLK_BITS / WORD_W;

  logic [KEY_WORDS-1:0] key_we;
  logic [BLK_BITS-1:0]  res_q, res_d;

  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    logic [WORD_W-1:0] kq, kd;
    assign key_we[i] = wr_ok && (addr == ADDR_W'(i));
    always_comb kd = key_we[i] ? wdata : kq;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) kq <= '0;
      else        kq <= kd;
    assign key_out[KEY_BITS-1-i*WORD_W -: WORD_W] = kq;
  end

  for (genvar j = 0; j < BLK_WORDS; j++) begin : g_blk
    logic [WORD_W-1:0] bq, bd;
    logic              bwe;
    assign bwe = wr_ok && (addr == ADDR_W'(DATA_BASE + j));
    always_comb bd = bwe ? wdata : bq;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bq <= '0;
      else        bq <= bd;
    assign blk_out[BLK_BITS-1-j*WORD_W -: WORD_W] = bq;
  end

  assign key_touch = |key_we;

  always_comb res_d = res_load ? res_in : res_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;

  always_comb begin
    res_word = '0;
    for (int k = 0; k < BLK_WORDS; k++)
      if (addr == ADDR_W'(RES_BASE + k))
        res_word = res_q[BLK_BITS-1-k*WORD_W -: WORD_W];
  end

  // R1/R10: key only changes through an accepted write
  p_key_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(key_out));
endmodule

// File: rtl/blkc_seq.sv
module blkc_seq
  import blkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       wr_kv,
  input  logic       wr_ie,
  input  logic [1:0] wr_start,
  input  logic       key_touch,
  input  logic       res_rd,
  input  logic       eng_done,
  output logic       eng_keyload,
  output logic       eng_start,
  output logic       eng_decrypt,
  output logic       eng_key_valid,
  output logic       res_load,
  output logic       busy,
  output logic [7:0] ctrl_rb,
  output logic       irq
);
  seq_state_e state_q, state_d;
  logic       kv_q, kv_d, ie_q, ie_d, xp_q, xp_d, dir_q, dir_d, irq_q, irq_d;
  logic [1:0] st_q, st_d;

  always_comb begin
    state_d  = state_q;
    kv_d     = kv_q;
    ie_d     = ie_q;
    xp_d     = xp_q;
    dir_d    = dir_q;
    irq_d    = irq_q;
    st_d     = st_q;
    res_load = 1'b0;
    if (ctrl_we) begin
      kv_d  = wr_kv;
      ie_d  = wr_ie;
      st_d  = wr_start;
      irq_d = 1'b0;
      if (!wr_kv) xp_d = 1'b0;
    end
    if (res_rd)    irq_d = 1'b0;
    if (key_touch) xp_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (|st_q) begin
        st_d = 2'b00;
        if (kv_q) begin
          dir_d   = !st_q[0];
          state_d = xp_q ? ST_BREQ : ST_KREQ;
        end
      end
      ST_KREQ:  state_d = ST_KWAIT;
      ST_KWAIT: if (eng_done) begin
        xp_d    = 1'b1;
        state_d = ST_BREQ;
      end
      ST_BREQ:  state_d = ST_BWAIT;
      ST_BWAIT: if (eng_done) begin
        res_load = 1'b1;
        if (ie_q) irq_d = 1'b1;
        state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kv_q    <= 1'b0;
      ie_q    <= 1'b0;
      xp_q    <= 1'b0;
      dir_q   <= 1'b0;
      irq_q   <= 1'b0;
      st_q    <= 2'b00;
    end else begin
      state_q <= state_d;
      kv_q    <= kv_d;
      ie_q    <= ie_d;
      xp_q    <= xp_d;
      dir_q   <= dir_d;
      irq_q   <= irq_d;
      st_q    <= st_d;
    end
  end

  assign eng_keyload   = (state_q == ST_KREQ);
  assign eng_start     = (state_q == ST_BREQ);
  assign eng_decrypt   = dir_q;
  assign eng_key_valid = kv_q;
  assign busy          = (state_q != ST_IDLE) || (|st_q);
  assign ctrl_rb       = {kv_q, ie_q, 4'b0000, st_q};
  assign irq           = irq_q;

  // R8: interrupt only follows an engine completion
  p_irq_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(eng_done));
  // R5: key load only under a valid key
  p_keyload_kv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_keyload |-> eng_key_valid);
  // R5: block start is a single-cycle pulse
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R7: a start without key valid leaves the sequencer idle
  p_no_kv_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && (|st_q) && !kv_q) |=> state_q == ST_IDLE);
  // R4: start bits clear the cycle after they are taken
  p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|st_q) |=> !(|st_q));
endmodule

// File: rtl/blkc_regfront.sv
module blkc_regfront
  import blkc_pkg::*;
#(
  parameter int unsigned KEY_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_cs,
  input  logic [4:0]          bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_wait,
  output logic                irq,
  output logic [KEY_BITS-1:0] eng_key,
  output logic [127:0]        eng_block,
  output logic                eng_key_valid,
  output logic                eng_keyload,
  output logic                eng_start,
  output logic                eng_decrypt,
  input  logic                eng_done,
  input  logic [127:0]        eng_result
);
  localparam int unsigned BLK_BITS  = 128;
  localparam int unsigned KEY_WORDS = KEY_BITS / WORD_W;
  localparam int unsigned BLK_WORDS = BLK_BITS / WORD_W;

  logic [1:0]        rs_q;
  logic              rst_sn;
  logic              wr_req, wr_hit, wr_ok, ctrl_we, rd_req, res_rd;
  logic              busy, key_touch, res_load;
  logic [WORD_W-1:0] res_word;
  logic [7:0]        ctrl_rb;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_sn = rs_q[1];

  assign wr_req = bus_cs && bus_wr;
  assign rd_req = bus_cs && bus_rd;
  assign wr_hit = (bus_addr < ADDR_W'(KEY_WORDS))
               || ((bus_addr >= ADDR_W'(DATA_BASE)) && (bus_addr < ADDR_W'(DATA_BASE + BLK_WORDS)))
               || (bus_addr == ADDR_W'(CTRL_ADDR));
  assign bus_wait = wr_req && busy && wr_hit;
  assign wr_ok    = wr_req && !bus_wait;
  assign ctrl_we  = wr_ok && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign res_rd   = rd_req && (bus_addr >= ADDR_W'(RES_BASE))
                           && (bus_addr < ADDR_W'(RES_BASE + BLK_WORDS));

  blkc_regbank #(.KEY_BITS(KEY_BITS), .BLK_BITS(BLK_BITS)) u_bank (
    .clk(clk), .rst_n(rst_sn), .wr_ok(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .res_load(res_load), .res_in(eng_result), .key_out(eng_key), .blk_out(eng_block),
    .res_word(res_word), .key_touch(key_touch)
  );

  blkc_seq u_seq (
    .clk(clk), .rst_n(rst_sn), .ctrl_we(ctrl_we),
    .wr_kv(bus_wdata[CB_KV]), .wr_ie(bus_wdata[CB_IE]),
    .wr_start({bus_wdata[CB_DEC], bus_wdata[CB_ENC]}),
    .key_touch(key_touch), .res_rd(res_rd), .eng_done(eng_done),
    .eng_keyload(eng_keyload), .eng_start(eng_start), .eng_decrypt(eng_decrypt),
    .eng_key_valid(eng_key_valid), .res_load(res_load), .busy(busy),
    .ctrl_rb(ctrl_rb), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = {24'h0, ctrl_rb};
      else                                bus_rdata = res_word;
    end
  end

  // R10: a stalled write never reaches the key
  p_stall_key_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wait && bus_addr < ADDR_W'(KEY_WORDS)) |=> $stable(eng_key));
endmodule

// File: tb/blkc_regfront_tb.sv
module blkc_regfront_tb;
  localparam int LAT = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_wait, irq;
  logic [127:0] eng_key, eng_block;
  logic         eng_key_valid, eng_keyload, eng_start, eng_decrypt;
  logic         eng_done = 1'b0;
  logic [127:0] eng_result = '0;

  int checks = 0, fails = 0;
  int kl_cnt = 0, st_cnt = 0, cnt = 0;
  logic         blk_op = 1'b0;
  logic [127:0] stub_key = '0;

  always #4 clk = ~clk;

  blkc_regfront u_dut (.*);

  function automatic logic [127:0] f_enc(logic [127:0] d, logic [127:0] k);
    return {d[119:0], d[127:120]} ^ k;
  endfunction
  function automatic logic [127:0] f_dec(logic [127:0] d, logic [127:0] k);
    logic [127:0] y = d ^ k;
    return {y[7:0], y[127:8]};
  endfunction

  // behavioural engine stub
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_keyload) begin
      stub_key <= eng_key; kl_cnt <= kl_cnt + 1; cnt <= LAT; blk_op <= 1'b0;
    end else if (eng_start) begin
      st_cnt <= st_cnt + 1; cnt <= LAT; blk_op <= 1'b1;
      eng_result <= eng_decrypt ? f_dec(eng_block, stub_key) : f_enc(eng_block, stub_key);
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) eng_done <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    bus_wr = 0; bus_cs = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0; bus_cs = 0;
  endtask

  task automatic load_key(input logic [127:0] k);
    for (int i = 0; i < 4; i++) bus_write(5'(i), k[127-32*i -: 32]);
  endtask
  task automatic load_blk(input logic [127:0] b);
    for (int i = 0; i < 4; i++) bus_write(5'(8+i), b[127-32*i -: 32]);
  endtask
  task automatic read_res(output logic [127:0] r);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin bus_read(5'(16+i), w); r[127-32*i -: 32] = w; end
  endtask

  // waits for the block done pulse, checks irq one edge later
  task automatic wait_blk(input bit exp_irq, input string tag);
    int n = 0;
    @(negedge clk);
    while (!(eng_done && blk_op) && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(irq == exp_irq, tag, {127'b0, irq}, {127'b0, exp_irq});
  endtask

  task automatic run_op(input logic [31:0] cmd, input bit exp_irq, input string tag,
                        output logic [127:0] r);
    bus_write(5'd31, cmd);
    wait_blk(exp_irq, tag);
    read_res(r);
  endtask

  localparam logic [127:0] K1 = 128'h603DEB10_15CA71BE_2B73AEF0_857D7781;
  localparam logic [127:0] K2 = 128'h01234567_89ABCDEF_AAAAAAAA_55555555;
  localparam logic [127:0] D1 = 128'hAA221133_11441155_11661177_21212121;
  localparam logic [127:0] D2 = 128'hAA2211CC_11440055_11001177_2121BBBB;
  localparam logic [127:0] D3 = 128'h0F0F0F0F_12345678_9ABCDEF0_CAFEF00D;

  task automatic t_reset;
    logic [31:0] w;
    chk(irq == 0 && eng_keyload == 0 && eng_start == 0, "R11 outputs idle",
        {irq, eng_keyload, eng_start}, 0);
    chk(bus_rdata == 0, "R3 idle rdata zero", bus_rdata, 0);
    bus_read(5'd31, w);
    chk(w == 0, "R11 control zero", w, 0);
  endtask

  task automatic t_encrypt;
    logic [127:0] r; logic [31:0] w;
    load_key(K1); load_blk(D1);
    run_op(32'hC1, 1, "R8 irq after enc", r);
    chk(r == f_enc(D1, K1), "R1 R2 R3 encrypt result", r, f_enc(D1, K1));
    chk(kl_cnt == 1 && st_cnt == 1, "R5 one key load", kl_cnt, 1);
    chk(irq == 0, "R9 irq cleared by result read", irq, 0);
    bus_read(5'd31, w);
    chk(w == 32'hC0, "R4 start bits self-clear", w, 32'hC0);
    bus_read(5'd0, w);
    chk(w == 0, "R3 key address reads zero", w, 0);
  endtask

  task automatic t_decrypt_repeat;
    logic [127:0] r;
    run_op(32'hC2, 1, "R8 irq after dec", r);
    chk(r == f_dec(D1, K1), "R4 decrypt result", r, f_dec(D1, K1));
    chk(kl_cnt == 1, "R5 no reload on decrypt", kl_cnt, 1);
    run_op(32'hC1, 1, "R8 irq after repeat", r);
    chk(r == f_enc(D1, K1), "R6 repeat after decrypt", r, f_enc(D1, K1));
    chk(kl_cnt == 1 && st_cnt == 3, "R5 reuse expanded key", kl_cnt, 1);
  endtask

  task automatic t_stall;
    logic [127:0] r;
    load_blk(D2);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = 5'd31; bus_wdata = 32'hC1;
    @(negedge clk);
    bus_addr = 5'd8; bus_wdata = D3[127:96];
    #1 chk(bus_wait == 1, "R10 wait on block write while busy", bus_wait, 1);
    while (bus_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    bus_wr = 0; bus_cs = 0;
    read_res(r);
    chk(r == f_enc(D2, K1), "R10 op used old block", r, f_enc(D2, K1));
    for (int i = 1; i < 4; i++) bus_write(5'(8+i), D3[127-32*i -: 32]);
    run_op(32'hC1, 1, "R8 irq after stalled write", r);
    chk(r == f_enc(D3, K1), "R10 stalled write applied later", r, f_enc(D3, K1));
  endtask

  task automatic t_invalidate;
    logic [127:0] r; logic [31:0] w;
    int kl0, st0;
    bus_write(5'd31, 32'h0);
    kl0 = kl_cnt; st0 = st_cnt;
    bus_write(5'd31, 32'h41);
    repeat (30) @(negedge clk);
    chk(kl_cnt == kl0 && st_cnt == st0 && irq == 0, "R7 start ignored without key valid",
        st_cnt, st0);
    bus_read(5'd31, w);
    chk(w == 32'h40, "R7 key valid cleared", w, 32'h40);
    load_key(K2);
    run_op(32'hC1, 1, "R8 irq new key", r);
    chk(r == f_enc(D3, K2), "R7 new key result", r, f_enc(D3, K2));
    chk(kl_cnt == kl0 + 1, "R7 key reloaded", kl_cnt, kl0 + 1);
  endtask

  task automatic t_irq_paths;
    logic [127:0] r;
    int kl0 = kl_cnt;
    bus_write(5'd3, 32'h77777777);
    run_op(32'h81, 0, "R8 irq stays low when disabled", r);
    chk(r == f_enc(D3, {K2[127:32], 32'h77777777}), "R5 key word rewrite reloads",
        r, f_enc(D3, {K2[127:32], 32'h77777777}));
    chk(kl_cnt == kl0 + 1, "R5 reload after key write", kl_cnt, kl0 + 1);
    bus_write(5'd31, 32'hC2);
    wait_blk(1, "R8 irq before control clear");
    bus_write(5'd31, 32'hC0);
    chk(irq == 0, "R9 irq cleared by control write", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_encrypt();
    t_decrypt_repeat();
    t_stall();
    t_invalidate();
    t_irq_paths();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule